// File: doc/BRIEF.md
# Predicated Vector Arithmetic Right Shift by Doubleword Counts

This block shifts every lane of a fixed-length vector right arithmetically, replicating each lane's top bit into the vacated positions. A 2-bit size code sets the lane width to 8, 16 or 32 bits. The shift count for a lane is not taken from a lane of the same width. It is the full unsigned 64-bit doubleword of the second operand that covers the lane's bit position, so all the narrow lanes inside one doubleword share that doubleword's count. The count is used at its full width with no modulo reduction. Any count at or above the lane width therefore fills the lane with its sign bit.

A per-byte predicate vector gates each lane. The predicate bit at the lane's lowest byte governs the lane. A lane whose governing bit is clear returns the first operand's lane unchanged, so the result can be written straight back over the first source register. The size code 11 has no lane width. A valid request carrying it raises an illegal-encoding flag and leaves the result untouched.

The shift and merge logic is combinational. An output stage, which is registered by default, presents the result, a result-valid strobe and the illegal flag one cycle after the input strobe.

Top module: `vec_wide_sra`

## Requirements
- R1: in_size selects the lane width as 8 << in_size: 00 gives 8-bit lanes, 01 gives 16-bit lanes and 10 gives 32-bit lanes. Lane e occupies result bits [e*W +: W].
- R2: A valid request with in_size = 11 sets out_illegal one cycle later, keeps out_valid low, and leaves out_res at its previous value.
- R3: The count for lane e is the unsigned doubleword in_opb[64*k +: 64], where k = (e*W)/64.
- R4: All 64 count bits are significant. Any count >= W, including counts with only high bits set and 2^64-1, makes every bit of the lane equal to the lane's sign bit.
- R5: A count c below W gives the lane arithmetically shifted right by c. A count of 0 returns the lane unchanged, and W-1 leaves only sign copies.
- R6: A lane whose governing predicate bit is clear returns the corresponding in_opa lane unchanged.
- R7: The governing predicate bit for lane e is in_pred[e*W/8]. The other predicate bits inside the lane have no effect on the result.
- R8: With the default registered output, out_valid is high exactly one cycle after a valid legal request, and out_res then carries that request's result. A cycle with no request leaves out_valid and out_illegal low and holds out_res.
- R9: A synchronous active-low reset clears out_res to zero and drives out_valid and out_illegal low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_size | input | 2 | Lane width code (00: 8, 01: 16, 10: 32, 11: illegal) |
| in_opa | input | VLEN | Operand to shift, and the source of inactive lanes |
| in_opb | input | VLEN | Doubleword shift counts |
| in_pred | input | VLEN/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Illegal size code was requested |
| out_res | output | VLEN | Result vector |

## Verification
The bench builds the block with VLEN = 256 and the output register enabled. With this vector length there are exactly four doublewords, so one request can give each doubleword its own boundary count (0, W-1, W, 2^64-1) in every lane width. In byte mode, eight lanes share each of those counts. The width also leaves room for predicate patterns that set only the non-governing bits of a lane. The registered default makes the one-cycle latency and the hold behaviour on illegal and idle cycles observable.

// File: rtl/vws_pkg.sv
// Package: shared types and constants for the vector wide-count shifter.
// Assumes counts are always 64-bit doublewords.
package vws_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } lane_size_e;

    localparam int unsigned CNT_W     = 64;
    localparam int unsigned NUM_SIZES = 3;

    // Lane width in bits for a legal size code.
    function automatic int unsigned lane_bits(input int unsigned code);
        return 8 << code;
    endfunction

endpackage

// File: rtl/vws_lane_sra.sv
// Module: one lane's arithmetic right shift by a full-width unsigned count.
// Assumes LW is a power of two smaller than 2**CW. Counts >= LW give a sign fill.
module vws_lane_sra #(
    parameter int unsigned LW = 8,
    parameter int unsigned CW = 64
) (
    input  logic [LW-1:0] din,
    input  logic [CW-1:0] cnt,
    output logic [LW-1:0] dout
);
    localparam int unsigned SW = $clog2(LW);

    logic                 oversize;
    logic signed [LW-1:0] sdin;
    logic signed [LW-1:0] shifted;

    // Any set bit above the in-range shift field means count >= LW.
    assign oversize = |cnt[CW-1:SW];
    assign sdin     = din;

    // In-range shift with sign replication.
    always_comb begin
        shifted = sdin >>> cnt[SW-1:0];
    end

    // Select the sign fill for oversized counts.
    always_comb begin
        dout = oversize ? {LW{din[LW-1]}} : shifted;
    end

endmodule

// File: rtl/vws_width_slice.sv
// Module: the whole-vector result for one fixed lane width, predicate merge included.
// Assumes VLEN is a multiple of CW and CW is a multiple of LW.
module vws_width_slice #(
    parameter int unsigned VLEN = 256,
    parameter int unsigned LW   = 8,
    parameter int unsigned CW   = 64
) (
    input  logic [VLEN-1:0]   opa,
    input  logic [VLEN-1:0]   opb,
    input  logic [VLEN/8-1:0] pred,
    output logic [VLEN-1:0]   res
);
    localparam int unsigned NLANE = VLEN / LW;
    localparam int unsigned PSTEP = LW / 8;
    localparam int unsigned LPD   = CW / LW;

    // Bits that only serve wider or narrower modes are folded here to mark them as intended.
    logic unused_pred;
    assign unused_pred = ^pred;

    for (genvar e = 0; e < NLANE; e++) begin : g_lane
        localparam int unsigned DW = e / LPD;
        logic [LW-1:0] shl;

        vws_lane_sra #(.LW(LW), .CW(CW)) u_sra (
            .din  (opa[e*LW +: LW]),
            .cnt  (opb[DW*CW +: CW]),
            .dout (shl)
        );

        // Governing predicate bit picks the shifted or the original lane.
        assign res[e*LW +: LW] = pred[e*PSTEP] ? shl : opa[e*LW +: LW];
    end

endmodule

// File: rtl/vws_out_stage.sv
// Module: output stage. Registered or pass-through, it holds the last legal result.
// Assumes rst_n is synchronous and active low.
module vws_out_stage #(
    parameter int unsigned VLEN    = 256,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic            bad,
    input  logic [VLEN-1:0] nxt_res,
    output logic            out_valid,
    output logic            out_illegal,
    output logic [VLEN-1:0] out_res
);
    logic [VLEN-1:0] held;

    // Keep the last legal result so that illegal and idle cycles show it.
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (fire) held <= nxt_res;
    end

    if (OUT_REG) begin : g_reg
        logic vld_q, bad_q;

        // Register the strobes one cycle behind the request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                bad_q <= 1'b0;
            end else begin
                vld_q <= fire;
                bad_q <= bad;
            end
        end

        assign out_valid   = vld_q;
        assign out_illegal = bad_q;
        assign out_res     = held;
    end else begin : g_comb
        assign out_valid   = fire;
        assign out_illegal = bad;
        assign out_res     = fire ? nxt_res : held;
    end

endmodule

// File: rtl/vec_wide_sra.sv
// Module: predicated vector arithmetic right shift, with counts from overlapping doublewords.
// Assumes VLEN is a multiple of 64. Size code 11 is rejected with out_illegal.
module vec_wide_sra #(
    parameter int unsigned VLEN    = 256,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_size,
    input  logic [VLEN-1:0]   in_opa,
    input  logic [VLEN-1:0]   in_opb,
    input  logic [VLEN/8-1:0] in_pred,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [VLEN-1:0]   out_res
);
    import vws_pkg::*;

    localparam int unsigned PW = VLEN / 8;

    logic [VLEN-1:0] slice_res [NUM_SIZES];
    logic [VLEN-1:0] sel_res;
    logic            size_bad;
    logic            fire;
    logic            bad;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_width
        vws_width_slice #(.VLEN(VLEN), .LW(lane_bits(s)), .CW(CNT_W)) u_slice (
            .opa  (in_opa),
            .opb  (in_opb),
            .pred (in_pred[PW-1:0]),
            .res  (slice_res[s])
        );
    end

    // Decode the size code into a legality flag.
    assign size_bad = (lane_size_e'(in_size) == SZ_BAD);
    assign fire     = in_valid & ~size_bad;
    assign bad      = in_valid &  size_bad;

    // Pick the slice that matches the requested lane width.
    always_comb begin
        case (lane_size_e'(in_size))
            SZ_BYTE: sel_res = slice_res[0];
            SZ_HALF: sel_res = slice_res[1];
            SZ_WORD: sel_res = slice_res[2];
            default: sel_res = in_opa;
        endcase
    end

    vws_out_stage #(.VLEN(VLEN), .OUT_REG(OUT_REG)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .bad         (bad),
        .nxt_res     (sel_res),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_res     (out_res)
    );

endmodule

// File: rtl/vws_chk.sv
// Checker: timing and lane properties of vec_wide_sra, attached with bind.
// Assumes the registered output. With OUT_REG = 0 it checks nothing.
module vws_chk #(
    parameter int unsigned VLEN    = 256,
    parameter bit          OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_size,
    input logic [VLEN-1:0]   in_opa,
    input logic [VLEN-1:0]   in_opb,
    input logic [VLEN/8-1:0] in_pred,
    input logic              out_valid,
    input logic              out_illegal,
    input logic [VLEN-1:0]   out_res
);
    if (OUT_REG) begin : g_chk
        // R8
        valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ($past(in_valid) && $past(in_size) != 2'b11));

        // R2
        illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_illegal |-> ($past(in_valid) && $past(in_size) == 2'b11));

        // R2
        illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_illegal |-> $stable(out_res));

        // R6
        inactive_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(in_valid && in_size == 2'b00 && !in_pred[0])
            |-> out_res[7:0] == $past(in_opa[7:0]));

        // R4
        word_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(in_valid && in_size == 2'b10 && in_pred[0] && (|in_opb[63:5]))
            |-> out_res[31:0] == {32{$past(in_opa[31])}});

        // R5
        zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(in_valid && in_size == 2'b01 && in_pred[0] && in_opb[63:0] == 64'd0)
            |-> out_res[15:0] == $past(in_opa[15:0]));
    end

endmodule

bind vec_wide_sra vws_chk #(.VLEN(VLEN), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/vec_wide_sra_tb.sv
`timescale 1ns/1ps
module vec_wide_sra_tb;
    localparam int unsigned VLEN = 256;
    localparam int unsigned PW   = VLEN / 8;
    localparam int unsigned LIMIT = 200000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [1:0]      in_size = 2'b00;
    logic [VLEN-1:0] in_opa = '0;
    logic [VLEN-1:0] in_opb = '0;
    logic [PW-1:0]   in_pred = '0;
    logic            out_valid;
    logic            out_illegal;
    logic [VLEN-1:0] out_res;

    int n_chk = 0;
    int n_fail = 0;
    logic [VLEN-1:0] held = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vec_wide_sra #(.VLEN(VLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_size(in_size),
        .in_opa(in_opa), .in_opb(in_opb), .in_pred(in_pred),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_res(out_res)
    );

    // Expected vector, computed bit by bit from the requirements.
    function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                                              input logic [PW-1:0] p, input int sz);
        int lw;
        logic [VLEN-1:0] r;
        lw = 8 << sz;
        r = a;
        for (int e = 0; e < VLEN / lw; e++) begin
            logic [63:0] c;
            logic sgn;
            c = b[(e * lw / 64) * 64 +: 64];
            sgn = a[e * lw + lw - 1];
            if (p[e * lw / 8]) begin
                for (int k = 0; k < lw; k++) begin
                    if (c >= 64'(lw - k)) r[e * lw + k] = sgn;
                    else r[e * lw + k] = a[e * lw + k + int'(c)];
                end
            end
        end
        return r;
    endfunction

    function automatic logic [VLEN-1:0] rand_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i * 32 +: 32] = $urandom();
        return v;
    endfunction

    task automatic check_vec(input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then check the outputs at the next falling edge.
    task automatic apply(input logic v, input logic [1:0] sz, input logic [VLEN-1:0] a,
                         input logic [VLEN-1:0] b, input logic [PW-1:0] p, input string tag);
        logic ok;
        logic [VLEN-1:0] exp;
        in_valid = v; in_size = sz; in_opa = a; in_opb = b; in_pred = p;
        ok = v && (sz != 2'b11);
        exp = ok ? model(a, b, p, int'(sz)) : held;
        @(posedge clk);
        @(negedge clk);
        check_bit({tag, " R8 valid"}, out_valid, ok);
        check_bit({tag, " R2 illegal"}, out_illegal, v && (sz == 2'b11));
        check_vec({tag, " result"}, out_res, exp);
        held = exp;
    endtask

    function automatic logic [VLEN-1:0] bound_counts(input int lw);
        logic [VLEN-1:0] b;
        b = rand_vec();
        b[63:0]    = 64'd0;
        b[127:64]  = 64'(lw - 1);
        b[191:128] = 64'(lw);
        b[255:192] = '1;
        return b;
    endfunction

    initial begin
        #(5.0 * LIMIT);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [VLEN-1:0] a;
        logic [VLEN-1:0] b;
        logic [PW-1:0] p;
        void'($urandom(32'h5eed_0042));
        in_opa = '1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: outputs after reset
        check_bit("R9 valid", out_valid, 1'b0);
        check_bit("R9 illegal", out_illegal, 1'b0);
        check_vec("R9 result", out_res, '0);
        rst_n = 1'b1;

        // R1 R3 R4 R5: boundary counts, a different one per doubleword, in each width
        for (int s = 0; s < 3; s++) begin
            apply(1'b1, 2'(s), rand_vec(), bound_counts(8 << s), '1, "R1 R3 R4 R5 bounds");
            apply(1'b1, 2'(s), {8{32'h8000_0001}}, bound_counts(8 << s), '1, "R4 R5 negative bounds");
        end

        // R4: only the top count bit set, then a count just above the shift field
        b = {4{64'h8000_0000_0000_0000}};
        apply(1'b1, 2'b10, {8{32'hC3A5_0F01}}, b, '1, "R4 high-bit count");
        b = {4{64'd33}};
        apply(1'b1, 2'b10, {8{32'h7FFF_FFFF}}, b, '1, "R4 count 33");

        // R6: all predicate bits clear
        a = rand_vec();
        apply(1'b1, 2'b00, a, {4{64'd3}}, '0, "R6 inactive");
        check_vec("R6 passthrough", out_res, a);

        // R7: only non-governing bits set in word mode leaves every lane unchanged
        a = rand_vec();
        apply(1'b1, 2'b10, a, {4{64'd5}}, {8{4'b1110}}, "R7 non-governing");
        check_vec("R7 ignored bits", out_res, a);
        apply(1'b1, 2'b01, rand_vec(), {4{64'd4}}, {16{2'b01}}, "R7 governing only");

        // R2: illegal size holds the previous result
        apply(1'b1, 2'b11, rand_vec(), rand_vec(), '1, "R2 illegal");
        // R8: idle cycle
        apply(1'b0, 2'b00, rand_vec(), rand_vec(), '1, "R8 idle");

        // Random mix, with counts biased toward the interesting range
        for (int i = 0; i < 400; i++) begin
            logic [1:0] sz;
            sz = 2'($urandom_range(0, 3));
            a = rand_vec();
            b = rand_vec();
            for (int d = 0; d < 4; d++) begin
                case ($urandom_range(0, 3))
                    0: b[d * 64 +: 64] = 64'($urandom_range(0, 40));
                    1: b[d * 64 +: 64] = '1;
                    2: b[d * 64 +: 64] = 64'((8 << (sz == 2'b11 ? 0 : sz)) - 1);
                    default: ;
                endcase
            end
            p = PW'({$urandom(), $urandom()});
            apply(($urandom_range(0, 9) != 0), sz, a, b, p, "R1 R3 R5 R6 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule